// File: doc/BRIEF.md
# Tagless Loop Cache Controller

This block sits between a processor's fetch port and its main instruction cache and saves fetch energy on small, tight loops. It watches the decoded fetch stream for a taken backward branch whose displacement is short enough for the loop body to fit in a small local array. The next pass through the loop is fetched from the main cache as usual, and each returned instruction is also written into the array. Every later pass is served from the array with the main cache disabled.

The array holds no address tags and no valid bits. Correctness depends only on the controller. It records the loop length from the branch displacement and counts its position inside the body, so it always knows whether the next fetch will find its instruction in the array. The main-cache enable for a fetch is registered one cycle earlier. Each fetch returns its instruction in the cycle it is requested, from whichever source was selected, so switching sources costs no cycles. Loops may start at any word address, because the array is indexed by the low bits of the fetch word address.

Top module: `lpc_top`

## Requirements
- R1: After reset the controller is idle, `mc_en` is 1, and `mc_req` follows `fe_req`.
- R2: A loop is recognised only when `br_sbb` and `br_taken` are both 1, `cof_taken` is 0, and `br_off` (backward displacement in words) satisfies 0 < `br_off` < DEPTH. The loop body is then `br_off`+1 words ending at the branch. A displacement of DEPTH or more leaves `mc_en` at 1 on every pass.
- R3: During the pass that follows the recognising branch, every fetch has `mc_en` = 1, and `fe_rdata` equals the main-cache word for `fe_addr`.
- R4: From the third pass onward, every fetch inside the body sees `mc_en` = 0 and `mc_req` = 0, and `fe_rdata` still equals the main-cache word for `fe_addr`.
- R5: Every fetch returns its word in the same cycle it is requested. `mc_en` for a fetch is a registered value fixed in an earlier cycle.
- R6: Loops starting at any word address are handled. The array index is `fe_addr[log2(DEPTH)-1:0]`.
- R7: During the fill pass, a taken `cof_taken`, or the loop branch falling through (`br_taken` = 0 on the last body word), abandons the fill. The controller returns to idle and `mc_en` stays 1.
- R8: While serving from the array, a taken `cof_taken` or the loop branch falling through makes the very next fetch use the main cache (`mc_en` = 1).
- R9: A cycle with `fe_req` = 0 changes neither the controller state nor `mc_en`.
- R10: A new loop whose addresses alias an earlier loop's array entries returns only its own instructions. No stale data is served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_req | input | 1 | Processor fetch request this cycle |
| fe_addr | input | AW | Fetch word address |
| fe_rdata | output | DW | Instruction returned to the processor in the same cycle |
| br_sbb | input | 1 | The fetched word is a short backward branch |
| br_taken | input | 1 | That branch resolves taken |
| br_off | input | OFFW | Backward displacement of that branch, in words |
| cof_taken | input | 1 | Any other control transfer in the fetched word is taken |
| mc_req | output | 1 | Main-cache access strobe (`fe_req` and `mc_en`) |
| mc_en | output | 1 | Main-cache enable, registered one cycle ahead |
| mc_addr | output | AW | Main-cache word address |
| mc_data | input | DW | Main-cache read data, combinational in the request cycle |

## Verification
A wrong position count or a missed fill write shows up as a wrong instruction on `fe_rdata` on the first served fetch, which is the opening word of the third pass. A controller stuck in a serving state after an exit shows up one fetch later. In that case `mc_en` stays low and the main-cache model returns a poison word. An overlooked abort or a mis-qualified branch shows up as `mc_en` falling on a pass where it must stay high. Every fetch therefore compares both the returned word and the enable against values computed from the loop geometry.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        LPC_IDLE   = 2'd0,
        LPC_FILL   = 2'd1,
        LPC_ACTIVE = 2'd2
    } lpc_state_t;

endpackage

// File: rtl/lpc_detect.sv
// Qualifies the decoded branch information of the word fetched this cycle.
module lpc_detect #(
    parameter int DEPTH = 32,
    parameter int OFFW  = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic            br_sbb,
    input  logic            br_taken,
    input  logic [OFFW-1:0] br_off,
    input  logic            cof_taken,
    output logic            loop_take,
    output logic            back_taken,
    output logic            redirect,
    output logic [IW-1:0]   off_idx
);

    localparam logic [OFFW-1:0] LIMIT = OFFW'(DEPTH);

    logic fits;

    always_comb begin
        fits       = (br_off != '0) && (br_off < LIMIT);
        back_taken = br_sbb && br_taken;
        loop_take  = back_taken && fits && !cof_taken;
        redirect   = back_taken || cof_taken;
        off_idx    = br_off[IW-1:0];
    end

endmodule

// File: rtl/lpc_array.sv
// Tagless, valid-less direct-mapped instruction store.
module lpc_array #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/lpc_ctrl.sv
// Idle / fill / active sequencing with a position counter inside the body.
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OFFW  = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fe_req,
    input  logic            loop_take,
    input  logic            back_taken,
    input  logic            redirect,
    input  logic            cof_taken,
    input  logic [IW-1:0]   off_idx,
    input  logic [OFFW-1:0] br_off,
    output lpc_state_t      state,
    output logic            serve,
    output logic            wr_en
);

    typedef struct packed {
        lpc_state_t    state;
        logic [IW-1:0] pos;
        logic [IW-1:0] last;
        logic          serve;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{state: LPC_IDLE, pos: '0, last: '0, serve: 1'b0};

    ctrl_t cur_q, nxt_d;
    logic  at_end;
    logic  loop_again;

    always_comb begin
        nxt_d      = cur_q;
        wr_en      = 1'b0;
        at_end     = (cur_q.pos == cur_q.last);
        loop_again = back_taken && !cof_taken && (br_off == OFFW'(cur_q.last));
        case (cur_q.state)
            LPC_IDLE: begin
                if (fe_req && loop_take) begin
                    nxt_d.state = LPC_FILL;
                    nxt_d.pos   = '0;
                    nxt_d.last  = off_idx;
                    nxt_d.serve = 1'b0;
                end
            end
            LPC_FILL: begin
                if (fe_req) begin
                    wr_en = 1'b1;
                    if (at_end) begin
                        if (loop_again) begin
                            nxt_d.state = LPC_ACTIVE;
                            nxt_d.pos   = '0;
                            nxt_d.serve = 1'b1;
                        end else begin
                            nxt_d = CTRL_RST;
                        end
                    end else if (redirect) begin
                        nxt_d = CTRL_RST;
                    end else begin
                        nxt_d.pos = cur_q.pos + 1'b1;
                    end
                end
            end
            LPC_ACTIVE: begin
                if (fe_req) begin
                    if (at_end) begin
                        if (loop_again) begin
                            nxt_d.pos = '0;
                        end else begin
                            nxt_d = CTRL_RST;
                        end
                    end else if (redirect) begin
                        nxt_d = CTRL_RST;
                    end else begin
                        nxt_d.pos = cur_q.pos + 1'b1;
                    end
                end
            end
            default: nxt_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= CTRL_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        state = cur_q.state;
        serve = cur_q.serve;
    end

endmodule

// File: rtl/lpc_top.sv
module lpc_top
    import lpc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int OFFW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fe_req,
    input  logic [AW-1:0]   fe_addr,
    output logic [DW-1:0]   fe_rdata,
    input  logic            br_sbb,
    input  logic            br_taken,
    input  logic [OFFW-1:0] br_off,
    input  logic            cof_taken,
    output logic            mc_req,
    output logic            mc_en,
    output logic [AW-1:0]   mc_addr,
    input  logic [DW-1:0]   mc_data
);

    localparam int IW = $clog2(DEPTH);

    logic          loop_take;
    logic          back_taken;
    logic          redirect;
    logic [IW-1:0] off_idx;
    lpc_state_t    ctl_state;
    logic          serve;
    logic          arr_we;
    logic [DW-1:0] arr_rdata;
    logic [IW-1:0] idx;

    assign idx = fe_addr[IW-1:0];

    lpc_detect #(.DEPTH(DEPTH), .OFFW(OFFW), .IW(IW)) u_detect (
        .br_sbb     (br_sbb),
        .br_taken   (br_taken),
        .br_off     (br_off),
        .cof_taken  (cof_taken),
        .loop_take  (loop_take),
        .back_taken (back_taken),
        .redirect   (redirect),
        .off_idx    (off_idx)
    );

    lpc_ctrl #(.DEPTH(DEPTH), .OFFW(OFFW), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fe_req     (fe_req),
        .loop_take  (loop_take),
        .back_taken (back_taken),
        .redirect   (redirect),
        .cof_taken  (cof_taken),
        .off_idx    (off_idx),
        .br_off     (br_off),
        .state      (ctl_state),
        .serve      (serve),
        .wr_en      (arr_we)
    );

    lpc_array #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_array (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_idx  (idx),
        .wr_data (mc_data),
        .rd_idx  (idx),
        .rd_data (arr_rdata)
    );

    always_comb begin
        mc_en    = !serve;
        mc_req   = fe_req && mc_en;
        mc_addr  = fe_addr;
        fe_rdata = serve ? arr_rdata : mc_data;
    end

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker
    import lpc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OFFW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fe_req,
    input logic            br_sbb,
    input logic            br_taken,
    input logic [OFFW-1:0] br_off,
    input logic            cof_taken,
    input logic            mc_en,
    input logic            arr_we,
    input lpc_state_t      ctl_state
);

    localparam logic [OFFW-1:0] LIMIT = OFFW'(DEPTH);

    a_r1_idle_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == LPC_IDLE) |-> mc_en);

    a_r2_long_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == LPC_IDLE && fe_req && br_sbb && br_taken && br_off >= LIMIT)
        |=> (ctl_state == LPC_IDLE));

    a_r3_fill_uses_main: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == LPC_FILL && fe_req) |-> mc_en);

    a_r4_no_write_while_served: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_en |-> !arr_we);

    a_r8_cof_reenables: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_req && cof_taken) |=> mc_en);

    a_r9_hold_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_req |=> $stable(mc_en));

    a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_req |=> $stable(ctl_state));

endmodule

bind lpc_top lpc_checker #(.DEPTH(DEPTH), .OFFW(OFFW)) u_lpc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fe_req    (fe_req),
    .br_sbb    (br_sbb),
    .br_taken  (br_taken),
    .br_off    (br_off),
    .cof_taken (cof_taken),
    .mc_en     (mc_en),
    .arr_we    (arr_we),
    .ctl_state (ctl_state)
);

// File: tb/lpc_top_test.sv
`timescale 1ns/1ps
module lpc_top_test;

    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 32;
    localparam int OFFW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fe_req = 1'b0;
    logic [AW-1:0]   fe_addr = '0;
    logic [DW-1:0]   fe_rdata;
    logic            br_sbb = 1'b0;
    logic            br_taken = 1'b0;
    logic [OFFW-1:0] br_off = '0;
    logic            cof_taken = 1'b0;
    logic            mc_req;
    logic            mc_en;
    logic [AW-1:0]   mc_addr;
    logic [DW-1:0]   mc_data;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
        return {~a, a} ^ 32'h5A5A_0F0F;
    endfunction

    // main cache model: poison when not accessed
    assign mc_data = mc_req ? ref_word(mc_addr) : 32'hBAD0_BAD0;

    lpc_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .OFFW(OFFW)) uut (
        .clk(clk), .rst_n(rst_n), .fe_req(fe_req), .fe_addr(fe_addr),
        .fe_rdata(fe_rdata), .br_sbb(br_sbb), .br_taken(br_taken),
        .br_off(br_off), .cof_taken(cof_taken), .mc_req(mc_req),
        .mc_en(mc_en), .mc_addr(mc_addr), .mc_data(mc_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fetch(input logic [AW-1:0] a, input bit sbb, input bit tk,
                         input int off, input bit cof, input bit exp_en, input string tag);
        @(negedge clk);
        fe_req    = 1'b1;
        fe_addr   = a;
        br_sbb    = sbb;
        br_taken  = tk;
        br_off    = OFFW'(off);
        cof_taken = cof;
        #2;
        check({tag, " data"}, fe_rdata, ref_word(a));
        check({tag, " mc_en"}, {31'd0, mc_en}, {31'd0, exp_en});
    endtask

    task automatic bubble(input bit exp_en, input string tag);
        @(negedge clk);
        fe_req    = 1'b0;
        br_sbb    = 1'b0;
        br_taken  = 1'b0;
        br_off    = '0;
        cof_taken = 1'b0;
        #2;
        check({tag, " bubble mc_en"}, {31'd0, mc_en}, {31'd0, exp_en});
        check({tag, " bubble mc_req"}, {31'd0, mc_req}, 32'd0);
    endtask

    // Runs a loop of off+1 words; optional exit by cof at (cof_it, cof_pos).
    task automatic run_loop(input logic [AW-1:0] start, input int off, input int iters,
                            input int cof_it, input int cof_pos, input bit stall,
                            input string tag);
        int  len;
        bit  short_ok;
        bit  exited;
        bit  en;
        len      = off + 1;
        short_ok = (off > 0) && (off < DEPTH);
        exited   = 1'b0;
        for (int it = 0; it < iters && !exited; it++) begin
            for (int k = 0; k < len && !exited; k++) begin
                en = !(short_ok && it >= 2);
                if (stall && k == 1) bubble(en, tag);
                if (it == cof_it && k == cof_pos) begin
                    fetch(start + AW'(k), 1'b0, 1'b0, 0, 1'b1, en, {tag, " cof"});
                    exited = 1'b1;
                end else if (k == len - 1) begin
                    fetch(start + AW'(k), 1'b1, it < iters - 1, off, 1'b0, en, tag);
                end else begin
                    fetch(start + AW'(k), 1'b0, 1'b0, 0, 1'b0, en, tag);
                end
            end
        end
        for (int j = 0; j < 3; j++) begin
            fetch(16'h3000 + AW'(j), 1'b0, 1'b0, 0, 1'b0, 1'b1, {tag, " after exit"});
        end
        bubble(1'b1, {tag, " idle"});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 reset mc_en", {31'd0, mc_en}, 32'd1);
        check("R1 reset mc_req", {31'd0, mc_req}, 32'd0);
        fetch(16'h0010, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R1 first fetch");
        check("R1 mc_req follows fe_req", {31'd0, mc_req}, 32'd1);
        bubble(1'b1, "R1");
    endtask

    task automatic t_basic;      run_loop(16'h0100, 7, 5, -1, 0, 1'b0, "R3 R4 R5 basic"); endtask
    task automatic t_unaligned;  run_loop(16'h1235, 4, 4, -1, 0, 1'b0, "R6 unaligned"); endtask
    task automatic t_max;        run_loop(16'h0400, DEPTH - 1, 3, -1, 0, 1'b0, "R2 max length"); endtask
    task automatic t_too_long;   run_loop(16'h0500, DEPTH, 4, -1, 0, 1'b0, "R2 too long"); endtask
    task automatic t_fill_cof;   run_loop(16'h0600, 9, 5, 1, 4, 1'b0, "R7 fill cof"); endtask
    task automatic t_fill_fall;  run_loop(16'h0700, 6, 2, -1, 0, 1'b0, "R7 fill fallthrough"); endtask
    task automatic t_active_cof; run_loop(16'h0800, 10, 6, 3, 5, 1'b0, "R8 active cof"); endtask
    task automatic t_active_fall; run_loop(16'h0850, 3, 4, -1, 0, 1'b0, "R8 active fallthrough"); endtask
    task automatic t_stall;      run_loop(16'h0900, 6, 5, -1, 0, 1'b1, "R9 stall"); endtask
    task automatic t_alias;
        run_loop(16'h0A20, 7, 4, -1, 0, 1'b0, "R10 first");
        run_loop(16'h0B40, 7, 4, -1, 0, 1'b0, "R10 aliasing");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_unaligned();
        t_max();
        t_too_long();
        t_fill_cof();
        t_fill_fall();
        t_active_cof();
        t_active_fall();
        t_stall();
        t_alias();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule